// File: doc/BRIEF.md
# EPROM Program-Verify Sequencer

This block programs a range of a byte-wide ultraviolet-erasable or one-time-programmable memory from a data source. Erased cells read as all ones, and each program pulse can only clear bits. For every address from a start address up to a last address, the sequencer raises the programming supplies and presents the address and source byte. It then applies a fixed-width active-low program strobe, waits out the hold and release gaps, and reads the byte back in verify mode. It moves on to the next address when the read-back equals the source byte. Otherwise it pulses again, up to a fixed limit, and gives up with a failure when the limit is reached.

Once the last byte has been programmed, the sequencer runs two full read-back sweeps over the same range. The first runs at the higher check supply and the second at the lower one. It ends with a pass, or with a failure and the first address that did not match. The power stage is steered by a 2-bit supply code. All timing windows are counted in clock cycles derived from a clock-frequency parameter.

Devices that share the address, data and strobe lines but are not selected keep their chip enable high and are not programmed. The source is addressed by the same address bus, and `srcData` must reflect `memAddr` combinationally.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset and while idle, `ceN`, `oeN` and `pgmN` are high, `supplySel` is 2'b00 (read levels), `memDataOe`, `busy`, `pass` and `fail` are low.
- R2: Every falling edge of `pgmN` is preceded by at least SETUP_US*CLK_MHZ cycles in which `supplySel` is 2'b01 (programming supplies), `ceN` is low, and address and data are driven. The code 2'b01 and `ceN` low are held throughout the pulse.
- R3: Each program pulse holds `pgmN` low for exactly PULSE_US*CLK_MHZ cycles.
- R4: After `pgmN` rises, data stays driven for HOLD_US*CLK_MHZ cycles and is then released. At least GAP_US*CLK_MHZ further cycles pass before `oeN` falls. Data is never driven while `oeN` is low.
- R5: Verify reads with `ceN` and `oeN` low, `pgmN` high and 2'b01 still applied, and samples after the access window. On a match the next address starts with its pulse count cleared. On a mismatch another pulse is applied.
- R6: A byte receives at most MAX_PULSES pulses (default 25). A byte matching after its final allowed pulse is accepted. A byte still mismatching after it ends the run with a failure.
- R7: Only addresses from `startAddr` to `lastAddr` inclusive are pulsed. With `startAddr` equal to `lastAddr`, exactly one byte is programmed.
- R8: After the last byte, every address in the range is read with `supplySel` 2'b10 (high check), then every address with 2'b11 (low check). Any mismatch ends the run with a failure at that address.
- R9: A run that passes both sweeps sets `pass`, clears `busy`, and returns `supplySel` to 2'b00 with `ceN` high.
- R10: On failure, `fail` is set, `failAddr` holds the failing address, `pass` stays low, and supplies and `ceN` return to read and deselected levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run when idle |
| startAddr | input | AW | First address to program |
| lastAddr | input | AW | Last address to program |
| srcData | input | DW | Source byte for the current `memAddr` |
| memDataIn | input | DW | Data read back from the memory |
| memAddr | output | AW | Address to memory and source |
| memDataOut | output | DW | Data to program |
| memDataOe | output | 1 | Drive enable for `memDataOut` |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| pgmN | output | 1 | Program strobe, active low |
| supplySel | output | 2 | 00 read, 01 program, 10 high check, 11 low check |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run passed (sticky until next start) |
| fail | output | 1 | Last run failed (sticky until next start) |
| failAddr | output | AW | Address that caused the failure |

## Verification
Every cycle, the assertions check that a strobe only occurs with the programming supplies selected and the device enabled. They also check that data is never driven while output enable is low, that a pulse ends exactly when its window expires, that the pulse count stays within its limit, that the address never steps past the last address, and that a failure lands at read levels. The remaining behaviour only shows in the bench's scenarios, run against a memory model whose cells need a set number of pulses:

- the setup, hold and gap windows measured around each pulse;
- the exact number of pulses per byte, including the boundary at the limit;
- that addresses outside the range are left untouched;
- that both check sweeps cover the whole range;
- which address a failure reports.

// File: rtl/burn_pkg.sv
package burn_pkg;

  typedef enum logic [1:0] {
    SUP_READ   = 2'b00,
    SUP_PROG   = 2'b01,
    SUP_CHK_HI = 2'b10,
    SUP_CHK_LO = 2'b11
  } supply_e;

  typedef enum logic [2:0] {
    DUR_SETUP,
    DUR_PULSE,
    DUR_HOLD,
    DUR_GAP,
    DUR_ACCESS
  } dur_e;

  typedef struct packed {
    logic loadStart;
    logic incAddr;
    logic clrPulse;
    logic incPulse;
    logic ldTimer;
    dur_e dur;
    logic latchFail;
  } burn_cmd_t;

endpackage

// File: rtl/burn_dpath.sv
module burn_dpath
  import burn_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 8,
  parameter int CLK_MHZ    = 50,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_US   = 2,
  parameter int PULSE_US   = 100,
  parameter int HOLD_US    = 2,
  parameter int GAP_US     = 2,
  parameter int ACCESS_NS  = 100
) (
  input  logic          clk,
  input  logic          rstN,
  input  burn_cmd_t     cmd,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] lastAddr,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] memDataIn,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] failAddr,
  output logic          timerDone,
  output logic          atLast,
  output logic          pulseMax,
  output logic          match
);

  localparam int SETUP_CYC  = SETUP_US * CLK_MHZ;
  localparam int PULSE_CYC  = PULSE_US * CLK_MHZ;
  localparam int HOLD_CYC   = HOLD_US * CLK_MHZ;
  localparam int GAP_CYC    = GAP_US * CLK_MHZ;
  localparam int ACCESS_CYC = (ACCESS_NS * CLK_MHZ + 999) / 1000 + 1;
  localparam int TW = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + GAP_CYC + ACCESS_CYC + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] loadVal;
  logic [PW-1:0] pulseCnt;

  always_comb begin
    case (cmd.dur)
      DUR_SETUP:  loadVal = TW'(SETUP_CYC - 1);
      DUR_PULSE:  loadVal = TW'(PULSE_CYC - 1);
      DUR_HOLD:   loadVal = TW'(HOLD_CYC - 1);
      DUR_GAP:    loadVal = TW'(GAP_CYC - 1);
      default:    loadVal = TW'(ACCESS_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      failAddr <= '0;
      pulseCnt <= '0;
      timer    <= '0;
    end else begin
      if (cmd.loadStart)    addr <= startAddr;
      else if (cmd.incAddr) addr <= addr + 1'b1;

      if (cmd.clrPulse)      pulseCnt <= '0;
      else if (cmd.incPulse) pulseCnt <= pulseCnt + 1'b1;

      if (cmd.ldTimer)        timer <= loadVal;
      else if (timer != '0)   timer <= timer - 1'b1;

      if (cmd.latchFail) failAddr <= addr;
    end
  end

  assign timerDone = (timer == '0);
  assign atLast    = (addr == lastAddr);
  assign pulseMax  = (pulseCnt >= PW'(MAX_PULSES));
  assign match     = (memDataIn == srcData);

  // R6: pulse count never exceeds the per-byte limit
  a_r6_pulse_cap: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PW'(MAX_PULSES));

  // R7: the address never steps beyond the last address
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    cmd.incAddr |-> (addr != lastAddr));

endmodule

// File: rtl/burn_ctrl.sv
module burn_ctrl
  import burn_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      timerDone,
  input  logic      match,
  input  logic      atLast,
  input  logic      pulseMax,
  output burn_cmd_t cmd,
  output logic      ceN,
  output logic      oeN,
  output logic      pgmN,
  output logic      memDataOe,
  output supply_e   supplySel,
  output logic      busy,
  output logic      passFlag,
  output logic      failFlag
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_GAP, ST_VERIFY,
    ST_CSET_HI, ST_CRD_HI, ST_CSET_LO, ST_CRD_LO
  } state_e;

  state_e st, nxt;
  logic   finishOk;

  always_comb begin
    nxt      = st;
    cmd      = '0;
    cmd.dur  = DUR_SETUP;
    finishOk = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        cmd.loadStart = 1'b1; cmd.clrPulse = 1'b1;
        cmd.ldTimer = 1'b1; cmd.dur = DUR_SETUP; nxt = ST_SETUP;
      end
      ST_SETUP: if (timerDone) begin
        cmd.incPulse = 1'b1; cmd.ldTimer = 1'b1; cmd.dur = DUR_PULSE; nxt = ST_PULSE;
      end
      ST_PULSE: if (timerDone) begin
        cmd.ldTimer = 1'b1; cmd.dur = DUR_HOLD; nxt = ST_HOLD;
      end
      ST_HOLD: if (timerDone) begin
        cmd.ldTimer = 1'b1; cmd.dur = DUR_GAP; nxt = ST_GAP;
      end
      ST_GAP: if (timerDone) begin
        cmd.ldTimer = 1'b1; cmd.dur = DUR_ACCESS; nxt = ST_VERIFY;
      end
      ST_VERIFY: if (timerDone) begin
        if (match && atLast) begin
          cmd.loadStart = 1'b1; cmd.ldTimer = 1'b1; cmd.dur = DUR_SETUP; nxt = ST_CSET_HI;
        end else if (match) begin
          cmd.incAddr = 1'b1; cmd.clrPulse = 1'b1;
          cmd.ldTimer = 1'b1; cmd.dur = DUR_SETUP; nxt = ST_SETUP;
        end else if (pulseMax) begin
          cmd.latchFail = 1'b1; nxt = ST_IDLE;
        end else begin
          cmd.ldTimer = 1'b1; cmd.dur = DUR_SETUP; nxt = ST_SETUP;
        end
      end
      ST_CSET_HI, ST_CSET_LO: if (timerDone) begin
        cmd.ldTimer = 1'b1; cmd.dur = DUR_ACCESS;
        nxt = (st == ST_CSET_HI) ? ST_CRD_HI : ST_CRD_LO;
      end
      ST_CRD_HI, ST_CRD_LO: if (timerDone) begin
        if (!match) begin
          cmd.latchFail = 1'b1; nxt = ST_IDLE;
        end else if (atLast && st == ST_CRD_HI) begin
          cmd.loadStart = 1'b1; cmd.ldTimer = 1'b1; cmd.dur = DUR_SETUP; nxt = ST_CSET_LO;
        end else if (atLast) begin
          finishOk = 1'b1; nxt = ST_IDLE;
        end else begin
          cmd.incAddr = 1'b1; cmd.ldTimer = 1'b1; cmd.dur = DUR_ACCESS;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      passFlag <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && start) begin
        passFlag <= 1'b0;
        failFlag <= 1'b0;
      end
      if (cmd.latchFail) failFlag <= 1'b1;
      if (finishOk)      passFlag <= 1'b1;
    end
  end

  always_comb begin
    ceN       = (st == ST_IDLE);
    oeN       = !(st inside {ST_VERIFY, ST_CRD_HI, ST_CRD_LO});
    pgmN      = (st != ST_PULSE);
    memDataOe = st inside {ST_SETUP, ST_PULSE, ST_HOLD};
    busy      = (st != ST_IDLE);
    case (st)
      ST_SETUP, ST_PULSE, ST_HOLD, ST_GAP, ST_VERIFY: supplySel = SUP_PROG;
      ST_CSET_HI, ST_CRD_HI:                          supplySel = SUP_CHK_HI;
      ST_CSET_LO, ST_CRD_LO:                          supplySel = SUP_CHK_LO;
      default:                                        supplySel = SUP_READ;
    endcase
  end

  // R2: a strobe only with programming supplies, device enabled, data driven
  a_r2_strobe_qualified: assert property (@(posedge clk) disable iff (!rstN)
    !pgmN |-> (supplySel == SUP_PROG && !ceN && oeN && memDataOe));

  // R4: no bus contention during reads
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !memDataOe);

  // R3: a pulse holds until its window expires, then ends
  a_r3_pulse_held: assert property (@(posedge clk) disable iff (!rstN)
    (!pgmN && !timerDone) |=> !pgmN);
  a_r3_pulse_ends: assert property (@(posedge clk) disable iff (!rstN)
    (!pgmN && timerDone) |=> pgmN);

  // R10: a failure lands at read levels with the device deselected
  a_r10_fail_safe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> (supplySel == SUP_READ && ceN && !passFlag));

  // R9: pass and fail are never reported together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag));

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
  import burn_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 8,
  parameter int CLK_MHZ    = 50,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_US   = 2,
  parameter int PULSE_US   = 100,
  parameter int HOLD_US    = 2,
  parameter int GAP_US     = 2,
  parameter int ACCESS_NS  = 100
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] lastAddr,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] memDataIn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  output logic          ceN,
  output logic          oeN,
  output logic          pgmN,
  output logic [1:0]    supplySel,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] failAddr
);

  burn_cmd_t cmd;
  supply_e   supplyCode;
  logic      timerDone, match, atLast, pulseMax;

  burn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .timerDone(timerDone), .match(match), .atLast(atLast), .pulseMax(pulseMax),
    .cmd(cmd), .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .memDataOe(memDataOe),
    .supplySel(supplyCode), .busy(busy), .passFlag(pass), .failFlag(fail)
  );

  burn_dpath #(
    .AW(AW), .DW(DW), .CLK_MHZ(CLK_MHZ), .MAX_PULSES(MAX_PULSES),
    .SETUP_US(SETUP_US), .PULSE_US(PULSE_US), .HOLD_US(HOLD_US),
    .GAP_US(GAP_US), .ACCESS_NS(ACCESS_NS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .startAddr(startAddr), .lastAddr(lastAddr),
    .srcData(srcData), .memDataIn(memDataIn),
    .addr(memAddr), .failAddr(failAddr),
    .timerDone(timerDone), .atLast(atLast), .pulseMax(pulseMax), .match(match)
  );

  assign supplySel  = supplyCode;
  assign memDataOut = srcData;

endmodule

// File: tb/tb_eprom_burn_seq.sv
module tb_eprom_burn_seq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int SETUP_C = 2;
  localparam int PULSE_C = 100;
  localparam int HOLD_C  = 2;
  localparam int GAP_C   = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] lastAddr = '0;
  logic [DW-1:0] srcData;
  logic [DW-1:0] memDataIn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDataOut;
  logic          memDataOe, ceN, oeN, pgmN, busy, pass, fail;
  logic [1:0]    supplySel;
  logic [AW-1:0] failAddr;

  always #2.5 clk = ~clk;

  eprom_burn_seq #(.AW(AW), .DW(DW), .CLK_MHZ(1), .MAX_PULSES(25)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .lastAddr(lastAddr),
    .srcData(srcData), .memDataIn(memDataIn), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .supplySel(supplySel),
    .busy(busy), .pass(pass), .fail(fail), .failAddr(failAddr)
  );

  int checks = 0;
  int errors = 0;
  int seed = 0;

  logic [DW-1:0] mem [N];
  int need [N];
  int pulses [N];
  int weakHi = -1;
  int weakLo = -1;
  int pwBad = 0, suBad = 0, gapBad = 0, ctBad = 0;
  logic [N-1:0] maskHi = '0, maskLo = '0;

  function automatic logic [DW-1:0] patOf(int a, int s);
    return DW'((a * 37 + s * 11 + 5) ^ (a << 4));
  endfunction

  assign srcData = patOf(int'(memAddr), seed);

  always_comb begin
    memDataIn = 8'hFF;
    if (!ceN && !oeN) begin
      memDataIn = mem[memAddr];
      if (supplySel == 2'b10 && int'(memAddr) == weakHi) memDataIn = memDataIn ^ 8'h01;
      if (supplySel == 2'b11 && int'(memAddr) == weakLo) memDataIn = memDataIn ^ 8'h80;
    end
  end

  // memory model and protocol monitors, sampled on the falling edge
  logic prevPgm = 1'b1;
  logic prevOe  = 1'b1;
  int   lowRun = 0, setupRun = 0, sinceRise = 1000, sinceRel = 1000;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPgm && !pgmN && !ceN && supplySel == 2'b01) begin
        pulses[memAddr] = pulses[memAddr] + 1;
        if (pulses[memAddr] >= need[memAddr]) mem[memAddr] = mem[memAddr] & memDataOut;
        if (setupRun < SETUP_C) suBad++;
      end
      if (!pgmN) lowRun++;
      if (!prevPgm && pgmN) begin
        if (lowRun != PULSE_C) pwBad++;
        lowRun = 0;
        sinceRise = 0;
      end else if (sinceRise < 1000) sinceRise++;
      if (memDataOe) sinceRel = 0; else if (sinceRel < 1000) sinceRel++;
      if (prevOe && !oeN && supplySel == 2'b01)
        if (sinceRise < HOLD_C + GAP_C || sinceRel < GAP_C + 1) gapBad++;
      if (!oeN && memDataOe) ctBad++;
      if (supplySel == 2'b01 && !ceN && memDataOe && pgmN) setupRun++; else setupRun = 0;
      if (supplySel == 2'b10 && !oeN) maskHi[memAddr] = 1'b1;
      if (supplySel == 2'b11 && !oeN) maskLo[memAddr] = 1'b1;
      prevPgm = pgmN;
      prevOe  = oeN;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel(input int s);
    seed = s;
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'hFF; need[a] = 1; pulses[a] = 0;
    end
    weakHi = -1; weakLo = -1;
    pwBad = 0; suBad = 0; gapBad = 0; ctBad = 0;
    maskHi = '0; maskLo = '0;
  endtask

  task automatic runSeq(input int s, input int l);
    int t;
    @(negedge clk);
    startAddr = AW'(s); lastAddr = AW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (busy && t < 60000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic idleChecks(input string tag);
    chk(ceN == 1'b1, tag, int'(ceN), 1);
    chk(supplySel == 2'b00, tag, int'(supplySel), 0);
    chk(busy == 1'b0, tag, int'(busy), 0);
  endtask

  task automatic timingChecks();
    chk(suBad == 0, "R2 setup before strobe", suBad, 0);
    chk(pwBad == 0, "R3 pulse width", pwBad, 0);
    chk(gapBad == 0, "R4 hold and gap before verify", gapBad, 0);
    chk(ctBad == 0, "R4 no drive during read", ctBad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearModel(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ceN && oeN && pgmN, "R1 control lines high", {ceN, oeN, pgmN}, 7);
    chk(supplySel == 2'b00, "R1 supply read", int'(supplySel), 0);
    chk(!memDataOe && !busy && !pass && !fail, "R1 status low",
        {memDataOe, busy, pass, fail}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // S1: full range, cells needing 1..3 pulses
    clearModel(1);
    for (int a = 0; a < N; a++) need[a] = (a % 3) + 1;
    runSeq(0, N - 1);
    chk(pass && !fail, "R9 full range pass", {pass, fail}, 2);
    idleChecks("R9 full range idle");
    for (int a = 0; a < N; a++) begin
      chk(mem[a] == patOf(a, 1), "R5 byte content", int'(mem[a]), int'(patOf(a, 1)));
      chk(pulses[a] == need[a], "R5 pulses per byte", pulses[a], need[a]);
    end
    chk(maskHi == '1, "R8 high check sweep", int'(maskHi), 16'hFFFF);
    chk(maskLo == '1, "R8 low check sweep", int'(maskLo), 16'hFFFF);
    timingChecks();

    // S2: subrange 5..9
    clearModel(2);
    runSeq(5, 9);
    chk(pass, "R7 subrange pass", int'(pass), 1);
    for (int a = 0; a < N; a++)
      chk(pulses[a] == ((a >= 5 && a <= 9) ? 1 : 0), "R7 pulses in range", pulses[a],
          (a >= 5 && a <= 9) ? 1 : 0);
    chk(maskLo == 16'h03E0, "R8 subrange low sweep", int'(maskLo), 16'h03E0);
    timingChecks();

    // S3: single byte needing exactly the limit
    clearModel(3);
    need[7] = 25;
    runSeq(7, 7);
    chk(pass && !fail, "R6 byte at limit passes", {pass, fail}, 2);
    chk(pulses[7] == 25, "R6 pulses at limit", pulses[7], 25);
    chk(mem[7] == patOf(7, 3), "R7 single byte written", int'(mem[7]), int'(patOf(7, 3)));
    timingChecks();

    // S4: byte needing more than the limit
    clearModel(4);
    need[6] = 26;
    runSeq(3, 10);
    chk(fail && !pass, "R10 over limit fails", {pass, fail}, 1);
    chk(failAddr == 4'd6, "R10 fail address", int'(failAddr), 6);
    chk(pulses[6] == 25, "R6 pulses capped", pulses[6], 25);
    chk(pulses[7] == 0, "R10 stops after failure", pulses[7], 0);
    idleChecks("R10 fail idle");

    // S5: weak at low check supply
    clearModel(5);
    weakLo = 12;
    runSeq(0, N - 1);
    chk(fail && !pass, "R8 low check fails", {pass, fail}, 1);
    chk(failAddr == 4'd12, "R8 low check fail address", int'(failAddr), 12);
    chk(maskHi == '1, "R8 high sweep before low", int'(maskHi), 16'hFFFF);
    idleChecks("R10 low check fail idle");

    // S6: weak at high check supply
    clearModel(6);
    weakHi = 3;
    runSeq(0, N - 1);
    chk(fail, "R8 high check fails", int'(fail), 1);
    chk(failAddr == 4'd3, "R8 high check fail address", int'(failAddr), 3);
    chk(maskLo == '0, "R8 low sweep skipped", int'(maskLo), 0);

    // S7: rerun after a failure clears the flags and passes
    clearModel(7);
    runSeq(2, 4);
    chk(pass && !fail, "R9 rerun after fail", {pass, fail}, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule